// File: doc/BRIEF.md
# I2C Configuration Target with Pointer-Based Readback

This block is an I2C target that gives a host access to a small configuration register map. Each write transaction carries a register-address byte and then one data byte. Every write is checked against the legal range of its target register. The result of each write attempt is kept in a status register. The block holds ten GPIO direction bits and drives them on `gpio_dir`.

Reads never carry a register address. A read transaction returns one byte, chosen by a pointer register. After any write that does not target the pointer, the pointer returns to the status register, so the host can always follow a write with a status read. To read anything else, the host first writes the wanted address into the pointer register at 0x01.

The link controller is a state machine with eight states:
- `LK_IDLE`: the bus is free.
- `LK_ADDR`: the target shifts in the address byte.
- `LK_ADDR_ACK`: the target drives the address acknowledge.
- `LK_WR_BYTE`: the target shifts in a write byte.
- `LK_WR_ACK`: the target drives the byte acknowledge.
- `LK_RD_BYTE`: the target shifts out a read byte.
- `LK_RD_ACK`: the target samples the host's acknowledge.
- `LK_WAIT`: the target ignores the bus until the next start or stop.

The transitions are:
- A stop moves any state to `LK_IDLE`.
- A start or repeated start moves any state to `LK_ADDR`.
- `LK_ADDR` goes to `LK_ADDR_ACK` after eight bits with a matching address, and to `LK_WAIT` on a foreign address.
- `LK_ADDR_ACK` goes to `LK_RD_BYTE` or `LK_WR_BYTE`, depending on the direction bit.
- `LK_WR_BYTE` goes to `LK_WR_ACK` for the first two bytes, and to `LK_WAIT` for any later byte.
- `LK_WR_ACK` returns to `LK_WR_BYTE`.
- `LK_RD_BYTE` goes to `LK_RD_ACK` after eight bits.
- `LK_RD_ACK` goes to `LK_WAIT` on a host NACK, and back to `LK_RD_BYTE` on a host ACK.

Top module: `i2c_cfg_target`

## Requirements
- R1: The target acknowledges the 7-bit address 0x6A (write byte 0xD4, read byte 0xD5). It never pulls SDA low for the rest of a transaction whose address differs.
- R2: A write is one register byte followed by one data byte, and the target acknowledges both. A third byte is not acknowledged and has no effect. A write stopped after the register byte alone changes neither the registers nor the status.
- R3: Addresses 0x10 to 0x19 each hold one direction bit; address 0x10+i drives `gpio_dir[i]`. These bits reset to 0 and accept the values 0 and 1.
- R4: A data value above 1 written to a direction register is rejected. The register keeps its old value and the status becomes 0x01.
- R5: The status codes are 0x00 for OK, 0x01 for an illegal value and 0x02 for an unknown register, and the status resets to 0x00. A write to any address outside 0x01 and 0x10 to 0x19 stores 0x02. This includes the readable addresses 0x00 and 0x30.
- R6: After any write attempt whose register byte is not 0x01, the pointer is 0x00, so the next read returns the status.
- R7: Writing 0x00 or 0x30 to the pointer register at 0x01 loads the pointer and stores status 0x00. Reads do not move the pointer, so repeated reads return the same register.
- R8: Writing any other value to the pointer register sets the pointer to 0x00 and stores status 0x01.
- R9: Address 0x30 reads back the direction bits of registers 0x10 to 0x17 packed into one byte, with bit i taken from register 0x10+i.
- R10: A read byte is sent MSB first. Any further byte the host acknowledges reads as 0xFF. After a host NACK the target releases SDA.
- R11: A repeated start begins a new transaction without a stop. A stop returns the target to idle with SDA released. A write cut short by a repeated start commits nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | I2C clock line as seen on the bus |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe | output | 1 | When 1, the pad pulls SDA low (open drain) |
| gpio_dir | output | NUM_DIR (10) | Direction bits, 1 = output, 0 = input |

## Verification
Several properties are checked on every cycle:
- The write strobe lasts exactly one cycle and never occurs in a read.
- A stop always releases SDA.
- The pointer only ever holds a readable address, and returns home after non-pointer writes.
- The direction bits move only on an accepted write.
- The status stays within its three codes.

Only the bench's bus scenarios can show the rest:
- the address match,
- the exact status code for each register and value,
- the pointer-selected readback and the packed bit order,
- the 0xFF fill after a host ACK,
- the handling of truncated transactions, overlong transactions and repeated starts.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    typedef enum logic [7:0] {
        ST_OK      = 8'h00,
        ST_ILLEGAL = 8'h01,
        ST_UNKNOWN = 8'h02
    } status_e;

    localparam logic [7:0] ADR_STATUS = 8'h00;
    localparam logic [7:0] ADR_PTR    = 8'h01;
    localparam logic [7:0] ADR_PACK   = 8'h30;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_ADDR_ACK,
        LK_WR_BYTE,
        LK_WR_ACK,
        LK_RD_BYTE,
        LK_RD_ACK,
        LK_WAIT
    } link_state_e;

endpackage

// File: rtl/i2c_cfg_sync.sv
module i2c_cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    // index 0 is the newest sample; STAGES-1 is the synchronized value;
    // STAGES holds the previous synchronized value for edge detection
    logic [STAGES:0] scl_pipe;
    logic [STAGES:0] sda_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-1:0], sda_i};
        end
    end

    logic scl_now, scl_old, sda_old;

    assign scl_now   = scl_pipe[STAGES-1];
    assign scl_old   = scl_pipe[STAGES];
    assign sda_s     = sda_pipe[STAGES-1];
    assign sda_old   = sda_pipe[STAGES];

    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign start_evt = scl_now & scl_old & sda_old & ~sda_s;
    assign stop_evt  = scl_now & scl_old & ~sda_old & sda_s;

endmodule

// File: rtl/i2c_cfg_link.sv
module i2c_cfg_link
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_evt,
    input  logic       stop_evt,
    input  logic       sda_s,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);

    localparam int         BITS     = 8;
    localparam logic [3:0] LAST_BIT = 4'(BITS);
    localparam logic [1:0] IDX_OVER = 2'd2;

    link_state_e state_q, state_d;
    logic [3:0]  cnt_q;
    logic [1:0]  idx_q;
    logic [7:0]  rx_q;
    logic [7:0]  tx_q;
    logic [7:0]  adr_q;
    logic [7:0]  dat_q;
    logic        rw_q;
    logic        nack_q;
    logic        stb_q;
    logic        addr_hit;
    logic        byte_done;

    assign addr_hit  = (rx_q[7:1] == DEV_ADDR);
    assign byte_done = scl_fall && (cnt_q == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = LK_IDLE;
        end else if (start_evt) begin
            state_d = LK_ADDR;
        end else begin
            unique case (state_q)
                LK_IDLE:     state_d = LK_IDLE;
                LK_ADDR:     if (byte_done) state_d = addr_hit ? LK_ADDR_ACK : LK_WAIT;
                LK_ADDR_ACK: if (scl_fall)  state_d = rw_q ? LK_RD_BYTE : LK_WR_BYTE;
                LK_WR_BYTE:  if (byte_done) state_d = (idx_q == IDX_OVER) ? LK_WAIT : LK_WR_ACK;
                LK_WR_ACK:   if (scl_fall)  state_d = LK_WR_BYTE;
                LK_RD_BYTE:  if (byte_done) state_d = LK_RD_ACK;
                LK_RD_ACK:   if (scl_fall)  state_d = nack_q ? LK_WAIT : LK_RD_BYTE;
                LK_WAIT:     state_d = LK_WAIT;
                default:     state_d = LK_IDLE;
            endcase
        end
    end

    // shift registers, counters and captured bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            idx_q  <= '0;
            rx_q   <= '0;
            tx_q   <= '1;
            adr_q  <= '0;
            dat_q  <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b1;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (start_evt || stop_evt) begin
                cnt_q <= '0;
                idx_q <= '0;
            end else begin
                unique case (state_q)
                    LK_ADDR: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[6:0], sda_s};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (byte_done) rw_q <= rx_q[0];
                    end
                    LK_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            idx_q <= '0;
                            tx_q  <= rd_data;
                        end
                    end
                    LK_WR_BYTE: begin
                        if (scl_rise) begin
                            rx_q  <= {rx_q[6:0], sda_s};
                            cnt_q <= cnt_q + 4'd1;
                        end
                        if (byte_done) begin
                            if (idx_q == 2'd0) begin
                                adr_q <= rx_q;
                            end else if (idx_q == 2'd1) begin
                                dat_q <= rx_q;
                                stb_q <= 1'b1;
                            end
                        end
                    end
                    LK_WR_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (idx_q != IDX_OVER) idx_q <= idx_q + 2'd1;
                        end
                    end
                    LK_RD_BYTE: begin
                        if (scl_rise) cnt_q <= cnt_q + 4'd1;
                        if (scl_fall && cnt_q != LAST_BIT) tx_q <= {tx_q[6:0], 1'b1};
                    end
                    LK_RD_ACK: begin
                        if (scl_rise) nack_q <= sda_s;
                        if (scl_fall) begin
                            cnt_q <= '0;
                            tx_q  <= 8'hFF;
                        end
                    end
                    LK_IDLE, LK_WAIT: begin
                        cnt_q <= '0;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_ADDR_ACK, LK_WR_ACK: sda_oe = 1'b1;
            LK_RD_BYTE:             sda_oe = ~tx_q[7];
            default:                sda_oe = 1'b0;
        endcase
    end

    assign wr_stb  = stb_q;
    assign wr_addr = adr_q;
    assign wr_data = dat_q;

    AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q); // R2

    AST_STB_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> !rw_q); // R2

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe); // R11

endmodule

// File: rtl/i2c_cfg_regs.sv
module i2c_cfg_regs
    import i2c_cfg_pkg::*;
#(
    parameter int         NUM_DIR  = 10,
    parameter logic [7:0] DIR_BASE = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_stb,
    input  logic [7:0]         wr_addr,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    output logic [NUM_DIR-1:0] dir_o
);

    localparam int         PACK_BITS = 8;
    localparam logic [7:0] DIR_END   = DIR_BASE + 8'(NUM_DIR - 1);

    status_e            status_q, status_d;
    logic [7:0]         ptr_q, ptr_d;
    logic [NUM_DIR-1:0] dir_q;
    logic               dir_we;
    logic               in_range;
    logic               ptr_ok;
    logic [7:0]         dir_idx;

    assign in_range = (wr_addr >= DIR_BASE) && (wr_addr <= DIR_END);
    assign ptr_ok   = (wr_data == ADR_STATUS) || (wr_data == ADR_PACK);
    assign dir_idx  = wr_addr - DIR_BASE;

    always_comb begin
        status_d = status_q;
        ptr_d    = ptr_q;
        dir_we   = 1'b0;
        if (wr_stb) begin
            ptr_d = ADR_STATUS;
            if (wr_addr == ADR_PTR) begin
                if (ptr_ok) begin
                    ptr_d    = wr_data;
                    status_d = ST_OK;
                end else begin
                    status_d = ST_ILLEGAL;
                end
            end else if (in_range) begin
                if (wr_data <= 8'd1) begin
                    dir_we   = 1'b1;
                    status_d = ST_OK;
                end else begin
                    status_d = ST_ILLEGAL;
                end
            end else begin
                status_d = ST_UNKNOWN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= ST_OK;
            ptr_q    <= ADR_STATUS;
        end else begin
            status_q <= status_d;
            ptr_q    <= ptr_d;
        end
    end

    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              dir_q[g] <= 1'b0;
            else if (dir_we && dir_idx == 8'(g))     dir_q[g] <= wr_data[0];
        end
    end

    assign rd_data = (ptr_q == ADR_PACK) ? dir_q[PACK_BITS-1:0] : 8'(status_q);
    assign dir_o   = dir_q;

    AST_PTR_READABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == ADR_STATUS) || (ptr_q == ADR_PACK)); // R7

    AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_addr != ADR_PTR) |=> (ptr_q == ADR_STATUS)); // R6

    AST_DIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && in_range && wr_data > 8'd1) |=> $stable(dir_q)); // R4

    AST_DIR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(dir_q)); // R3

    AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        8'(status_q) <= 8'd2); // R5

endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         NUM_DIR     = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe,
    output logic [NUM_DIR-1:0] gpio_dir
);

    logic       sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic       wr_stb;
    logic [7:0] wr_addr, wr_data, rd_data;

    i2c_cfg_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_cfg_link #(
        .DEV_ADDR (DEV_ADDR)
    ) i_link (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt),
        .sda_s     (sda_s),
        .rd_data   (rd_data),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    i2c_cfg_regs #(
        .NUM_DIR  (NUM_DIR),
        .DIR_BASE (8'h10)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .dir_o   (gpio_dir)
    );

endmodule

// File: tb/test_i2c_cfg_target.sv
module test_i2c_cfg_target;

    localparam int Q = 20;
    localparam int NV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [9:0] gpio_dir;
    logic [9:0] model = '0;
    int         n_chk = 0;
    int         n_err = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_cfg_target i_i2c_cfg_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_bus),
        .sda_oe   (sda_oe),
        .gpio_dir (gpio_dir)
    );

    // {register, data, expected status}
    localparam logic [23:0] VEC [NV] = '{
        24'h10_01_00, 24'h12_01_00, 24'h13_02_01, 24'h19_01_00,
        24'h05_00_02, 24'h30_01_02, 24'h00_00_02, 24'h17_01_00,
        24'h12_00_00, 24'h11_FF_01, 24'h14_01_00, 24'h1A_01_02
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait();
            scl_m = 1'b0;
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        ack = ~sda_bus;
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic host_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_m = 1'b1;
            repeat (Q/2) @(negedge clk);
            b[i] = sda_bus;
            repeat (Q/2) @(negedge clk);
            scl_m = 1'b0;
        end
        sda_m = ~host_ack; qwait();
        scl_m = 1'b1; qwait();
        scl_m = 1'b0;
        repeat (5) @(negedge clk);
        sda_m = 1'b1;
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d,
                             output logic [2:0] acks);
        logic k;
        i2c_start();
        send_byte(8'hD4, k); acks[2] = k;
        send_byte(a, k);     acks[1] = k;
        send_byte(d, k);     acks[0] = k;
        i2c_stop();
    endtask

    task automatic read_one(output logic [7:0] b, output logic ack);
        i2c_start();
        send_byte(8'hD5, ack);
        recv_byte(b, 1'b0);
        i2c_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] b, b2;
        logic       k;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // reset state
        check("R3", "gpio_dir after reset", 32'(gpio_dir), 32'h0);
        check("R11", "sda_oe idle", 32'(sda_oe), 32'h0);
        read_one(b, k);
        check("R1", "read address ack", 32'(k), 32'h1);
        check("R5", "status after reset", 32'(b), 32'h00);

        // table of writes, each followed by a status read
        for (int i = 0; i < NV; i++) begin
            logic [7:0] va, vd, vs;
            {va, vd, vs} = VEC[i];
            write_reg(va, vd, acks);
            check("R2", "write acks", 32'(acks), 32'h7);
            if (va >= 8'h10 && va <= 8'h19 && vd <= 8'd1)
                model[va - 8'h10] = vd[0];
            read_one(b, k);
            check("R5", $sformatf("status for %0h<=%0h (R6 pointer home)", va, vd), 32'(b), 32'(vs));
            check("R3", "gpio_dir vs model (R4 on rejected)", 32'(gpio_dir), 32'(model));
        end

        // pointer to packed readback
        write_reg(8'h01, 8'h30, acks);
        read_one(b, k);
        check("R9", "packed readback", 32'(b), 32'(model[7:0]));
        read_one(b, k);
        check("R7", "repeat read keeps pointer", 32'(b), 32'(model[7:0]));
        write_reg(8'h01, 8'h00, acks);
        read_one(b, k);
        check("R7", "pointer back to status, OK", 32'(b), 32'h00);

        // illegal pointer value
        write_reg(8'h01, 8'h30, acks);
        write_reg(8'h01, 8'h22, acks);
        read_one(b, k);
        check("R8", "illegal pointer status", 32'(b), 32'h01);

        // foreign address
        i2c_start();
        send_byte(8'hA0, k);
        check("R1", "foreign address not acked", 32'(k), 32'h0);
        send_byte(8'h10, k);
        check("R1", "foreign data not acked", 32'(k), 32'h0);
        i2c_stop();

        // truncated write
        write_reg(8'h15, 8'h01, acks);
        model[5] = 1'b1;
        i2c_start();
        send_byte(8'hD4, k);
        send_byte(8'h16, k);
        i2c_stop();
        read_one(b, k);
        check("R2", "status after truncated write", 32'(b), 32'h00);
        check("R2", "gpio_dir after truncated write", 32'(gpio_dir), 32'(model));

        // third byte
        i2c_start();
        send_byte(8'hD4, k);
        send_byte(8'h16, k);
        send_byte(8'h01, k);
        send_byte(8'h00, k);
        check("R2", "third byte nacked", 32'(k), 32'h0);
        i2c_stop();
        model[6] = 1'b1;
        check("R2", "second byte committed, third ignored", 32'(gpio_dir), 32'(model));

        // multi-byte read
        write_reg(8'h01, 8'h30, acks);
        i2c_start();
        send_byte(8'hD5, k);
        recv_byte(b, 1'b1);
        recv_byte(b2, 1'b0);
        check("R10", "first read byte", 32'(b), 32'(model[7:0]));
        check("R10", "fill byte after host ack", 32'(b2), 32'hFF);
        check("R10", "sda released after host nack", 32'(sda_oe), 32'h0);
        i2c_stop();

        // repeated start cutting a write short
        i2c_start();
        send_byte(8'hD4, k);
        send_byte(8'h18, k);
        i2c_start();
        send_byte(8'hD5, k);
        recv_byte(b, 1'b0);
        i2c_stop();
        check("R11", "read after cut write keeps pointer", 32'(b), 32'(model[7:0]));
        check("R11", "cut write commits nothing", 32'(gpio_dir), 32'(model));

        // full write then repeated start read
        i2c_start();
        send_byte(8'hD4, k);
        send_byte(8'h18, k);
        send_byte(8'h01, k);
        i2c_start();
        send_byte(8'hD5, k);
        recv_byte(b, 1'b0);
        i2c_stop();
        model[8] = 1'b1;
        check("R11", "status via repeated start", 32'(b), 32'h00);
        check("R3", "bit 8 set", 32'(gpio_dir), 32'(model));
        check("R11", "sda_oe after stop", 32'(sda_oe), 32'h0);

        // reset in the middle of operation
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R3", "gpio_dir after second reset", 32'(gpio_dir), 32'h0);
        read_one(b, k);
        check("R5", "status after second reset", 32'(b), 32'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule